// File: doc/BRIEF.md
# Dirty Line Eviction Buffer

This block sits between a data cache and the external memory write port. When a cache miss has to replace a dirty line, the cache controller hands over the whole victim line, eight 32-bit words together with its 32-byte-aligned physical line address, in a single cycle. The controller can then issue the refill read for the miss at once. The eviction write to memory waits until the refill has gone out.

The buffer drains on its own, one 32-bit word per write handshake, in ascending word order. It starts only when the memory port has no read pending. Once a drain has begun it runs to the end. While a line is held, a lookup port compares the line address of any incoming read with the buffered line. On a match it returns the requested word straight from the buffer, so a reader never gets a stale copy from memory. The buffer holds one line only, and a second eviction is stalled until the first has been written out completely.

Top module: `evict_line_buf`

## Requirements
- R1: A capture happens on a clock edge where `cap_valid_i` and `cap_ready_o` are both high. It stores all of `cap_data_i` in one step, with word i at bits [32*i+31:32*i], together with the 24-bit line address `cap_line_addr_i`, which holds physical address bits [28:5].
- R2: `full_o` is high from the edge after a capture until the edge that accepts the write of the last word. `cap_ready_o` is the inverse of `full_o`.
- R3: The drain writes words 0 to 7 in ascending order. Word i goes to byte address `{line_addr, i[2:0], 2'b00}` and carries the data of word i of the captured line.
- R4: A drain does not raise its first write request while `rd_pend_i` is high. Once raised, the request stays high through all eight words, whatever `rd_pend_i` does.
- R5: While `mem_wr_req_o` is high and `mem_wr_ack_i` is low, `mem_wr_addr_o` and `mem_wr_data_o` stay unchanged into the next cycle.
- R6: `hz_hit_o` is high in the same cycle when `hz_valid_i` is high, the buffer is full and `hz_line_addr_i` equals the stored line address. `hz_data_o` is then word `hz_word_i` of the stored line.
- R7: `hz_hit_o` is low, and `hz_data_o` is zero, when the buffer is empty or the line addresses differ.
- R8: After reset `full_o` is 0, `cap_ready_o` is 1, `mem_wr_req_o` is 0 and no lookup hits, so any previous contents are discarded.
- R9: In the cycle after the last word is acknowledged, `cap_ready_o` is high again, and a new capture made in that cycle is accepted.
- R10: A capture attempt while the buffer is full changes neither the stored line nor its address. Both stay visible through the lookup port and through the drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid_i | input | 1 | Victim line offered by the cache |
| cap_ready_o | output | 1 | Buffer empty, capture accepted |
| cap_line_addr_i | input | 24 | Victim physical address bits [28:5] |
| cap_data_i | input | 256 | Victim line, word i at [32*i+31:32*i] |
| full_o | output | 1 | A line is held or draining |
| rd_pend_i | input | 1 | A read request is pending on the memory port |
| mem_wr_req_o | output | 1 | Word write request |
| mem_wr_ack_i | input | 1 | Word write accepted |
| mem_wr_addr_o | output | 29 | Byte address of the word being written |
| mem_wr_data_o | output | 32 | Word being written |
| hz_valid_i | input | 1 | Incoming read to be checked |
| hz_line_addr_i | input | 24 | Read physical address bits [28:5] |
| hz_word_i | input | 3 | Word index within the line for the read |
| hz_hit_o | output | 1 | Read matches the buffered line |
| hz_data_o | output | 32 | Buffered word for a matching read |

## Verification
The hardest case to reach from the ports is a drain that has started and then sees a read become pending in the middle of the line. It has to be shown that the request is not withdrawn and that the words keep their order and values. The bench gets there by holding `rd_pend_i` high through the capture and for several cycles after it. It then releases the read and slows the acknowledge to every third cycle, so the drain is still in progress when `rd_pend_i` is raised again. A blocked second capture, a lookup into the held line, and a capture in the first free cycle after a drain are applied around this case.

// File: rtl/elb_pkg.sv
package elb_pkg;
    localparam int ELB_ADDR_W     = 29;
    localparam int ELB_WORD_W     = 32;
    localparam int ELB_LINE_WORDS = 8;

    typedef enum logic [1:0] {
        PH_EMPTY = 2'd0,
        PH_HELD  = 2'd1,
        PH_DRAIN = 2'd2
    } elb_phase_e;
endpackage

// File: rtl/elb_line_store.sv
module elb_line_store #(
    parameter int LINE_ADDR_W = 24,
    parameter int LINE_BITS   = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load_i,
    input  logic [LINE_ADDR_W-1:0] line_addr_i,
    input  logic [LINE_BITS-1:0]   line_data_i,
    output logic [LINE_ADDR_W-1:0] line_addr_o,
    output logic [LINE_BITS-1:0]   line_data_o
);
    typedef struct packed {
        logic [LINE_ADDR_W-1:0] addr;
        logic [LINE_BITS-1:0]   data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.addr = line_addr_i;
            st_d.data = line_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_addr_o = st_q.addr;
    assign line_data_o = st_q.data;
endmodule

// File: rtl/elb_drain_ctl.sv
module elb_drain_ctl
    import elb_pkg::*;
#(
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_valid_i,
    input  logic             rd_pend_i,
    input  logic             ack_i,
    output logic             cap_ready_o,
    output logic             load_o,
    output logic             full_o,
    output logic             req_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        elb_phase_e       ph;
        logic [IDX_W-1:0] idx;
    } ctl_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

    ctl_t ctl_d, ctl_q;
    logic fire;

    always_comb begin
        ctl_d       = ctl_q;
        cap_ready_o = (ctl_q.ph == PH_EMPTY);
        load_o      = cap_valid_i && cap_ready_o;
        req_o       = (ctl_q.ph == PH_DRAIN) || ((ctl_q.ph == PH_HELD) && !rd_pend_i);
        fire        = req_o && ack_i;
        unique case (ctl_q.ph)
            PH_EMPTY: begin
                if (load_o) begin
                    ctl_d.ph  = PH_HELD;
                    ctl_d.idx = '0;
                end
            end
            PH_HELD, PH_DRAIN: begin
                if (fire) begin
                    if (ctl_q.idx == LAST_IDX) begin
                        ctl_d.ph  = PH_EMPTY;
                        ctl_d.idx = '0;
                    end else begin
                        ctl_d.ph  = PH_DRAIN;
                        ctl_d.idx = ctl_q.idx + 1'b1;
                    end
                end else if (req_o) begin
                    ctl_d.ph = PH_DRAIN;
                end
            end
            default: ctl_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{ph: PH_EMPTY, idx: '0};
        else        ctl_q <= ctl_d;
    end

    assign full_o = (ctl_q.ph != PH_EMPTY);
    assign idx_o  = ctl_q.idx;
endmodule

// File: rtl/elb_hazard.sv
module elb_hazard #(
    parameter int LINE_ADDR_W = 24,
    parameter int WORD_W      = 32,
    parameter int LINE_WORDS  = 8,
    localparam int IDX_W      = $clog2(LINE_WORDS)
) (
    input  logic                         full_i,
    input  logic [LINE_ADDR_W-1:0]       held_addr_i,
    input  logic [LINE_WORDS*WORD_W-1:0] held_data_i,
    input  logic                         hz_valid_i,
    input  logic [LINE_ADDR_W-1:0]       hz_line_addr_i,
    input  logic [IDX_W-1:0]             hz_word_i,
    output logic                         hz_hit_o,
    output logic [WORD_W-1:0]            hz_data_o
);
    logic [WORD_W-1:0] words [LINE_WORDS];

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_split
        assign words[g] = held_data_i[g*WORD_W +: WORD_W];
    end

    always_comb begin
        hz_hit_o  = hz_valid_i && full_i && (hz_line_addr_i == held_addr_i);
        hz_data_o = hz_hit_o ? words[hz_word_i] : '0;
    end
endmodule

// File: rtl/evict_line_buf.sv
module evict_line_buf
    import elb_pkg::*;
#(
    parameter int ADDR_W     = ELB_ADDR_W,
    parameter int WORD_W     = ELB_WORD_W,
    parameter int LINE_WORDS = ELB_LINE_WORDS,
    localparam int IDX_W       = $clog2(LINE_WORDS),
    localparam int BYTE_W      = $clog2(WORD_W / 8),
    localparam int OFF_W       = IDX_W + BYTE_W,
    localparam int LINE_ADDR_W = ADDR_W - OFF_W,
    localparam int LINE_BITS   = LINE_WORDS * WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_valid_i,
    output logic                   cap_ready_o,
    input  logic [LINE_ADDR_W-1:0] cap_line_addr_i,
    input  logic [LINE_BITS-1:0]   cap_data_i,
    output logic                   full_o,
    input  logic                   rd_pend_i,
    output logic                   mem_wr_req_o,
    input  logic                   mem_wr_ack_i,
    output logic [ADDR_W-1:0]      mem_wr_addr_o,
    output logic [WORD_W-1:0]      mem_wr_data_o,
    input  logic                   hz_valid_i,
    input  logic [LINE_ADDR_W-1:0] hz_line_addr_i,
    input  logic [IDX_W-1:0]       hz_word_i,
    output logic                   hz_hit_o,
    output logic [WORD_W-1:0]      hz_data_o
);
    logic                   load;
    logic [IDX_W-1:0]       idx;
    logic [LINE_ADDR_W-1:0] held_addr;
    logic [LINE_BITS-1:0]   held_data;

    elb_drain_ctl #(.LINE_WORDS(LINE_WORDS)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_valid_i (cap_valid_i),
        .rd_pend_i   (rd_pend_i),
        .ack_i       (mem_wr_ack_i),
        .cap_ready_o (cap_ready_o),
        .load_o      (load),
        .full_o      (full_o),
        .req_o       (mem_wr_req_o),
        .idx_o       (idx)
    );

    elb_line_store #(.LINE_ADDR_W(LINE_ADDR_W), .LINE_BITS(LINE_BITS)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .line_addr_i (cap_line_addr_i),
        .line_data_i (cap_data_i),
        .line_addr_o (held_addr),
        .line_data_o (held_data)
    );

    elb_hazard #(
        .LINE_ADDR_W (LINE_ADDR_W),
        .WORD_W      (WORD_W),
        .LINE_WORDS  (LINE_WORDS)
    ) u_hz (
        .full_i         (full_o),
        .held_addr_i    (held_addr),
        .held_data_i    (held_data),
        .hz_valid_i     (hz_valid_i),
        .hz_line_addr_i (hz_line_addr_i),
        .hz_word_i      (hz_word_i),
        .hz_hit_o       (hz_hit_o),
        .hz_data_o      (hz_data_o)
    );

    assign mem_wr_addr_o = {held_addr, idx, BYTE_W'(0)};
    assign mem_wr_data_o = held_data[idx*WORD_W +: WORD_W];
endmodule

// File: rtl/elb_checker.sv
module elb_checker #(
    parameter int ADDR_W     = 29,
    parameter int WORD_W     = 32,
    parameter int LINE_WORDS = 8,
    localparam int IDX_W     = $clog2(LINE_WORDS),
    localparam int BYTE_W    = $clog2(WORD_W / 8)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_valid_i,
    input logic              cap_ready_o,
    input logic              full_o,
    input logic              rd_pend_i,
    input logic              mem_wr_req_o,
    input logic              mem_wr_ack_i,
    input logic [ADDR_W-1:0] mem_wr_addr_o,
    input logic [WORD_W-1:0] mem_wr_data_o,
    input logic              hz_valid_i,
    input logic              hz_hit_o
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINE_WORDS - 1);

    AST_CAP_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid_i && cap_ready_o) |=> full_o); // R1

    AST_READY_INVERSE: assert property (@(posedge clk) disable iff (!rst_n)
        full_o != cap_ready_o); // R2

    AST_STEP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req_o && mem_wr_ack_i && mem_wr_addr_o[BYTE_W +: IDX_W] != LAST_IDX)
        |=> (mem_wr_req_o && mem_wr_addr_o == $past(mem_wr_addr_o) + ADDR_W'(WORD_W / 8))); // R3

    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req_o |-> (mem_wr_addr_o[BYTE_W-1:0] == '0)); // R3

    AST_START_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_wr_req_o) |-> !rd_pend_i); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req_o && !mem_wr_ack_i) |=> mem_wr_req_o); // R4

    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req_o && !mem_wr_ack_i) |=> ($stable(mem_wr_addr_o) && $stable(mem_wr_data_o))); // R5

    AST_HIT_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        hz_hit_o |-> (full_o && hz_valid_i)); // R7

    AST_REQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req_o |-> full_o); // R8
endmodule

bind evict_line_buf elb_checker #(
    .ADDR_W     (ADDR_W),
    .WORD_W     (WORD_W),
    .LINE_WORDS (LINE_WORDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cap_valid_i   (cap_valid_i),
    .cap_ready_o   (cap_ready_o),
    .full_o        (full_o),
    .rd_pend_i     (rd_pend_i),
    .mem_wr_req_o  (mem_wr_req_o),
    .mem_wr_ack_i  (mem_wr_ack_i),
    .mem_wr_addr_o (mem_wr_addr_o),
    .mem_wr_data_o (mem_wr_data_o),
    .hz_valid_i    (hz_valid_i),
    .hz_hit_o      (hz_hit_o)
);

// File: tb/evict_line_buf_bench.sv
`timescale 1ns/1ps
module evict_line_buf_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cap_valid_i = 1'b0;
    logic         cap_ready_o;
    logic [23:0]  cap_line_addr_i = '0;
    logic [255:0] cap_data_i = '0;
    logic         full_o;
    logic         rd_pend_i = 1'b0;
    logic         mem_wr_req_o;
    logic         mem_wr_ack_i = 1'b0;
    logic [28:0]  mem_wr_addr_o;
    logic [31:0]  mem_wr_data_o;
    logic         hz_valid_i = 1'b0;
    logic [23:0]  hz_line_addr_i = '0;
    logic [2:0]   hz_word_i = '0;
    logic         hz_hit_o;
    logic [31:0]  hz_data_o;

    int applied = 0;
    int miscomp = 0;
    int ack_every = 1;
    int ack_cnt = 0;
    int popped = 0;
    logic [60:0] expq[$];
    logic        prev_hold = 1'b0;
    logic [60:0] prev_item = '0;

    always #2.5 clk = ~clk;

    evict_line_buf u_evict_line_buf (.*);

    function automatic logic [31:0] mkw(int seed, int i);
        return 32'(seed * 65536 + i * 4369 + 7);
    endfunction

    function automatic void check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        applied++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endfunction

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // driver: offers a line; pushes the expected writes only if accepted
    task automatic capture(logic [23:0] la, int seed);
        logic ok;
        cap_line_addr_i = la;
        for (int i = 0; i < 8; i++) cap_data_i[32*i +: 32] = mkw(seed, i);
        cap_valid_i = 1'b1;
        ok = cap_ready_o;
        if (ok) for (int i = 0; i < 8; i++) expq.push_back({la, 3'(i), 2'b00, mkw(seed, i)});
        step(1);
        cap_valid_i = 1'b0;
    endtask

    task automatic probe(logic [23:0] la, int w, logic exp_hit, logic [31:0] exp_data, string tag);
        hz_valid_i = 1'b1;
        hz_line_addr_i = la;
        hz_word_i = 3'(w);
        #1;
        check(tag, "hz_hit_o", 64'(hz_hit_o), 64'(exp_hit));
        check(tag, "hz_data_o", 64'(hz_data_o), 64'(exp_data));
        hz_valid_i = 1'b0;
    endtask

    task automatic wait_empty();
        while (full_o) step(1);
    endtask

    // acknowledge generator
    always @(posedge clk) begin
        #1;
        if (rst_n && mem_wr_req_o) begin
            ack_cnt++;
            mem_wr_ack_i = (ack_cnt % ack_every == 0);
        end else begin
            mem_wr_ack_i = 1'b0;
        end
    end

    // monitor: compares each accepted write against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_hold)
                check("R5", "held write", 64'({mem_wr_addr_o, mem_wr_data_o}), 64'(prev_item));
            if (mem_wr_req_o && mem_wr_ack_i) begin
                if (expq.size() == 0) begin
                    check("R3", "unexpected write", 64'({mem_wr_addr_o, mem_wr_data_o}), 64'(0));
                end else begin
                    logic [60:0] e;
                    e = expq.pop_front();
                    popped++;
                    check("R3", "write addr", 64'(mem_wr_addr_o), 64'(e[60:32]));
                    check("R1", "write data", 64'(mem_wr_data_o), 64'(e[31:0]));
                end
            end
            prev_hold = mem_wr_req_o && !mem_wr_ack_i;
            prev_item = {mem_wr_addr_o, mem_wr_data_o};
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscomp++;
        $display("FAIL watchdog R2: actual timeout expected drain completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        check("R8", "full_o", 64'(full_o), 64'(0));
        check("R8", "cap_ready_o", 64'(cap_ready_o), 64'(1));
        check("R8", "mem_wr_req_o", 64'(mem_wr_req_o), 64'(0));
        probe(24'h000000, 0, 1'b0, 32'h0, "R8");
        step(1);

        // line A with a read pending on the bus
        rd_pend_i = 1'b1;
        capture(24'hABC123, 5);
        check("R2", "full after capture", 64'(full_o), 64'(1));
        check("R2", "ready while full", 64'(cap_ready_o), 64'(0));
        for (int k = 0; k < 4; k++) begin
            check("R4", "no req while read pending", 64'(mem_wr_req_o), 64'(0));
            step(1);
        end
        probe(24'hABC123, 3, 1'b1, mkw(5, 3), "R6");
        probe(24'hABC123, 7, 1'b1, mkw(5, 7), "R6");
        probe(24'hABC124, 3, 1'b0, 32'h0, "R7");
        // R10 second capture while full is refused
        capture(24'h555555, 9);
        check("R10", "still full", 64'(full_o), 64'(1));
        probe(24'hABC123, 3, 1'b1, mkw(5, 3), "R10");
        probe(24'h555555, 3, 1'b0, 32'h0, "R10");
        // release the read, slow acknowledge, re-raise read mid drain
        ack_every = 3;
        rd_pend_i = 1'b0;
        #1;
        check("R4", "req after read clears", 64'(mem_wr_req_o), 64'(1));
        while (popped < 2) step(1);
        rd_pend_i = 1'b1;
        #1;
        check("R4", "req kept mid drain", 64'(mem_wr_req_o), 64'(1));
        wait_empty();
        check("R9", "ready after drain", 64'(cap_ready_o), 64'(1));
        check("R3", "all words written", 64'(expq.size()), 64'(0));
        probe(24'hABC123, 3, 1'b0, 32'h0, "R7");

        // line B, fast acknowledge, then back-to-back line C
        rd_pend_i = 1'b0;
        ack_every = 1;
        capture(24'h0F0F0F, 11);
        probe(24'h0F0F0F, 0, 1'b1, mkw(11, 0), "R6");
        wait_empty();
        check("R9", "ready in free cycle", 64'(cap_ready_o), 64'(1));
        capture(24'hFFFFFF, 13);
        check("R9", "back-to-back accepted", 64'(full_o), 64'(1));
        wait_empty();
        step(2);
        check("R3", "queue drained", 64'(expq.size()), 64'(0));
        check("R3", "write count", 64'(popped), 64'(24));

        // R8 reset mid-line discards contents
        capture(24'h123456, 17);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        expq.delete();
        #1;
        check("R8", "full after reset", 64'(full_o), 64'(0));
        probe(24'h123456, 2, 1'b0, 32'h0, "R8");
        step(3);
        check("R8", "no req after reset", 64'(mem_wr_req_o), 64'(0));

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
        $finish;
    end
endmodule